// File: doc/BRIEF.md
# Handshake Count Synchronizer

This block moves a binary count of any value from one clock domain to another. It does not depend on a code in which only one bit changes per step. The source side copies its live count into a holding register and flips a ready toggle. The destination side passes that toggle through a two-stage synchronizer. When it sees a change, it loads the held value into its output register, pulses an update strobe and flips an acknowledge toggle. The acknowledge toggle is synchronized back to the source. A new sample is taken only once the acknowledge toggle matches the ready toggle again.

Because the held value cannot change while a transfer is open, every bit the destination captures belongs to one sample. This holds for jumps, wrap-arounds and moduli that are not a power of two. The cost is a round trip through two synchronizers for each update.

Top module: `cnt_handshake_sync`

## Requirements
- R1: After reset, `dst_count` is 0, `dst_update` is 0 and no transfer is open: the ready and acknowledge toggles are both 0.
- R2: The source loads `src_count` into its holding register only while no transfer is open (ready toggle equals synchronized acknowledge toggle). The register holds its value while a transfer is open, so every value delivered is one that was driven on `src_count`.
- R3: Every load of the holding register flips the ready toggle exactly once, and the ready toggle changes at no other time.
- R4: When the synchronized ready toggle differs from the destination's acknowledge toggle, the destination loads the held value into `dst_count` and flips its acknowledge toggle in the same cycle.
- R5: `dst_update` is high for exactly one destination cycle: the cycle in which a newly captured value first appears on `dst_count`.
- R6: Values arrive unchanged and in the order they were driven. This includes non-sequential jumps, 0 and all-ones.
- R7: A value held on `src_count` long enough for two full round trips is delivered to `dst_count`.
- R8: A new value on `src_count` reaches `dst_count` no earlier than two destination clock cycles after it was driven.
- R9: The count width is a parameter `CW` with a default of 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_count | input | CW | Live binary count in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_count | output | CW | Last count captured in the destination domain |
| dst_update | output | 1 | One-cycle strobe marking a fresh `dst_count` |

## Verification
A value driven at a source falling edge reaches the ready toggle at the next source rising edge. It then needs two destination edges to pass the synchronizer and one more edge to be captured. The earliest new `dst_count` is therefore three destination edges after the change, with the strobe in the same cycle. The bench counts destination edges from each change and requires at least two, which keeps R8 independent of phase. Each value is held for 16 source cycles, which covers two round trips, before the bench requires that it was delivered. The monitor samples on destination falling edges, so it reads results between clock edges.

// File: rtl/cnt_handshake_sync_pkg.sv
package cnt_handshake_sync_pkg;

    localparam int DEF_CW     = 5;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_BUSY = 1'b1
    } link_state_e;

    // A transfer is open whenever the two toggles disagree.
    function automatic link_state_e link_state(input logic mine, input logic theirs);
        return (mine != theirs) ? LINK_BUSY : LINK_IDLE;
    endfunction

endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xfer_src.sv
module xfer_src
    import cnt_handshake_sync_pkg::*;
#(
    parameter int CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_in,
    input  logic          ack_tgl_s,
    output logic [CW-1:0] held,
    output logic          req_tgl
);
    link_state_e st;
    assign st = link_state(req_tgl, ack_tgl_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            req_tgl <= 1'b0;
        end else if (st == LINK_IDLE) begin
            held    <= cnt_in;
            req_tgl <= ~req_tgl;
        end
    end

    // R2
    held_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (req_tgl != ack_tgl_s) |=> $stable(held));

    // R3
    req_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (req_tgl != ack_tgl_s) |=> $stable(req_tgl));

endmodule

// File: rtl/xfer_dst.sv
module xfer_dst
    import cnt_handshake_sync_pkg::*;
#(
    parameter int CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_tgl_s,
    input  logic [CW-1:0] held,
    output logic          ack_tgl,
    output logic [CW-1:0] cnt_out,
    output logic          upd
);
    link_state_e st;
    assign st = link_state(req_tgl_s, ack_tgl);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_tgl <= 1'b0;
            cnt_out <= '0;
            upd     <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (st == LINK_BUSY) begin
                cnt_out <= held;
                ack_tgl <= ~ack_tgl;
                upd     <= 1'b1;
            end
        end
    end

    // R5
    upd_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd);

    // R4
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_tgl_s != ack_tgl) |=> (upd && cnt_out == $past(held)));

    // R1
    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            reset_clear_chk: assert (cnt_out == '0 && !upd && !ack_tgl);
        end
    end

endmodule

// File: rtl/cnt_handshake_sync.sv
module cnt_handshake_sync
    import cnt_handshake_sync_pkg::*;
#(
    parameter int CW = DEF_CW
) (
    input  logic          src_clk,
    input  logic          src_rst,
    input  logic [CW-1:0] src_count,
    input  logic          dst_clk,
    input  logic          dst_rst,
    output logic [CW-1:0] dst_count,
    output logic          dst_update
);
    logic [CW-1:0] held;
    logic          req_tgl, req_tgl_s;
    logic          ack_tgl, ack_tgl_s;

    xfer_src #(.CW(CW)) u_src (
        .clk       (src_clk),
        .rst       (src_rst),
        .cnt_in    (src_count),
        .ack_tgl_s (ack_tgl_s),
        .held      (held),
        .req_tgl   (req_tgl)
    );

    toggle_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (req_tgl),
        .q   (req_tgl_s)
    );

    toggle_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk (src_clk),
        .rst (src_rst),
        .d   (ack_tgl),
        .q   (ack_tgl_s)
    );

    xfer_dst #(.CW(CW)) u_dst (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_tgl_s (req_tgl_s),
        .held      (held),
        .ack_tgl   (ack_tgl),
        .cnt_out   (dst_count),
        .upd       (dst_update)
    );

endmodule

// File: tb/cnt_handshake_sync_bench.sv
module cnt_handshake_sync_bench;
    localparam int CW = 5;

    logic          src_clk = 1'b0, dst_clk = 1'b0;
    logic          src_rst = 1'b1, dst_rst = 1'b1;
    logic [CW-1:0] src_count = '0;
    logic [CW-1:0] dst_count;
    logic          dst_update;

    int total = 0, bad = 0;
    int dst_cyc = 0;
    int t_set = 0;
    logic [CW-1:0] exp_q[$];
    logic [CW-1:0] cur = '0;
    logic prev_upd = 1'b0;
    logic mon_on = 1'b0;
    logic fresh = 1'b0;
    bit   done = 1'b0;

    always #10 src_clk = ~src_clk;
    always #7  dst_clk = ~dst_clk;
    always @(posedge dst_clk) dst_cyc <= dst_cyc + 1;

    cnt_handshake_sync #(.CW(CW)) u_cnt_handshake_sync (
        .src_clk(src_clk), .src_rst(src_rst), .src_count(src_count),
        .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_count(dst_count), .dst_update(dst_update)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected values as captures appear.
    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (dst_update) begin
                // R5: strobe never two cycles running
                check(!prev_upd, "R5", prev_upd, 0);
                if (dst_count == cur) begin
                    check(1'b1, "R2", dst_count, cur);
                end else if (exp_q.size() > 0 && dst_count == exp_q[0]) begin
                    // R6: in order, unchanged
                    check(1'b1, "R6", dst_count, exp_q[0]);
                    cur = exp_q.pop_front();
                    // R8: lag of at least two destination cycles
                    check((dst_cyc - t_set) >= 2, "R8", dst_cyc - t_set, 2);
                    fresh = 1'b1;
                end else begin
                    // R2 R4: captured value was never driven or out of order
                    check(1'b0, "R2 R4", dst_count, (exp_q.size() > 0) ? exp_q[0] : cur);
                end
            end else if (fresh) begin
                // R5: strobe marks only the first cycle of a new value
                check(dst_count == cur, "R5", dst_count, cur);
            end
            prev_upd = dst_update;
        end
    end

    task automatic send(input logic [CW-1:0] v);
        @(negedge src_clk);
        exp_q.push_back(v);
        t_set = dst_cyc;
        src_count = v;
        repeat (16) @(negedge src_clk);
        // R7: value delivered within two round trips
        check(exp_q.size() == 0 && cur == v, "R7", cur, v);
        exp_q.delete();
        cur = v;
    endtask

    initial begin
        #200000000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge src_clk);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        @(negedge dst_clk);
        // R1: reset state
        check(dst_count == 0, "R1", dst_count, 0);
        check(dst_update == 1'b0, "R1", dst_update, 0);
        // R9: default width
        check($bits(dst_count) == 5, "R9", $bits(dst_count), 5);
        repeat (12) @(negedge src_clk);
        // R1: zero input keeps output at zero
        check(dst_count == 0, "R1", dst_count, 0);
        mon_on = 1'b1;
        send(5'd1);
        send(5'd2);
        send(5'd3);
        send(5'd17);  // jump
        send(5'd31);  // all ones
        send(5'd0);   // wrap to zero
        send(5'd10);
        send(5'd21);
        send(5'd4);
        // R6: last value held at output
        @(negedge dst_clk);
        check(dst_count == 5'd4, "R6", dst_count, 4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule